// File: doc/BRIEF.md
# Fixed off-time chopper controller

This block is the digital half of a current regulator for one winding of a bipolar stepper motor. It drives the four gate enables of one H-bridge: a high-side (source) and a low-side (sink) switch on each of the two legs. A polarity bit picks which diagonal pair conducts during the on phase. An external comparator reports when the winding current has reached its set level. The controller then ends the on phase and holds the bridge in a decay configuration for a fixed number of clock cycles. After that it turns the diagonal back on. The indexer chooses the decay style with a 2-bit code: slow, fast, or mixed (fast first, then slow inside the same off period).

Three programmable cycle counts shape the timing: the off time, the comparator blanking time that follows every change of the gate outputs, and the fast portion of mixed decay. The transistors opposite to the ones that were switched off can be turned on during decay to rectify synchronously. That feature can be disabled, and it shuts itself off for the rest of the period once a zero-current detect bit is seen. An output-disable input, a fault input and an active-low sleep input each force the bridge off. A step-ready output tells the indexer when the gate supply has had time to settle after sleep or reset.

Top module: `chop_phase_ctrl`

## Requirements
- R1: After reset all four gate outputs are 0 and `step_ready` is 0.
- R2: With `pol`=0 the on phase drives `src_a` and `snk_b`. With `pol`=1 it drives `src_b` and `snk_a`. The on phase starts two cycles after the bridge is released from the forced-off condition.
- R3: A trip ends the on phase only once the on pattern is present at the outputs and the blanking count has elapsed. The blanking count restarts on every change of the gate outputs. With `trip` held high, the on pattern lasts blank+2 cycles.
- R4: The off period occupies exactly off-time clock cycles. After that the controller returns to the on phase, subject to the dead-cycle rule of R10.
- R5: Slow decay (`decay_sel`=00) turns off only the on-phase source. The on-phase sink stays on, and with synchronous rectification the low-side switch on the source's leg is also on.
- R6: Fast decay (`decay_sel`=01) turns off both on-phase switches. With synchronous rectification, the switch complementary to each of them (same leg) is on.
- R7: Mixed decay (`decay_sel`=10 or 11) uses the fast pattern for the first fast-portion cycles of the off period and the slow pattern for the remainder. The fast portion is capped by the off time.
- R8: When `sr_dis` is high, no complementary switch is turned on during decay.
- R9: A `zero_det` pulse during the off period turns the complementary switches off from the next cycle until the period ends.
- R10: A source and a sink on the same leg are never on in the same cycle. Whenever one of them turns on after the other was on, one cycle with both off comes first.
- R11: Any of `out_dis` high, `fault` high or `sleep_n` low forces all gate outputs to 0 on the next cycle. The on phase resumes two cycles after the condition clears.
- R12: A zero in `off_len`, `blank_len` or `fast_len` acts as a count of one.
- R13: `step_ready` is 0 while `sleep_n` is low. After `sleep_n` rises it becomes 1 exactly `WAKE_CYC` clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_n | input | 1 | Low puts the bridge to sleep |
| out_dis | input | 1 | High forces all gates off |
| fault | input | 1 | Overtemperature or undervoltage; forces all gates off |
| trip | input | 1 | Current comparator has reached the set level |
| pol | input | 1 | Winding current polarity |
| decay_sel | input | 2 | 00 slow, 01 fast, 10/11 mixed |
| sr_dis | input | 1 | High disables synchronous rectification |
| zero_det | input | 1 | Winding current has reached zero |
| off_len | input | CW | Off time in cycles |
| blank_len | input | CW | Blanking time in cycles |
| fast_len | input | CW | Fast portion of mixed decay in cycles |
| src_a | output | 1 | Leg A high-side enable |
| snk_a | output | 1 | Leg A low-side enable |
| src_b | output | 1 | Leg B high-side enable |
| snk_b | output | 1 | Leg B low-side enable |
| step_ready | output | 1 | Step commands may be issued |

## Verification
The chopping cycle is swept over both polarities, all four decay codes, rectification on and off, and small off, blank and fast counts that include zero. With the comparator held high, every cycle of the gate sequence is compared against a model built from the requirements. The rectification-off cases isolate the decay patterns and interval lengths. The rectification-on cases add the dead cycles at each leg handover, including the fast-to-slow change inside mixed decay, and these separate an off-by-one in the dead-cycle rule from one in the counters. Directed runs then pulse the zero detect mid-period, raise the fault and disable inputs during the on phase, and time the step-ready delay after sleep.

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl #(
  parameter int CW = 8,
  parameter int WAKE_CYC = 125000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_n,
  input  logic          out_dis,
  input  logic          fault,
  input  logic          trip,
  input  logic          pol,
  input  logic [1:0]    decay_sel,
  input  logic          sr_dis,
  input  logic          zero_det,
  input  logic [CW-1:0] off_len,
  input  logic [CW-1:0] blank_len,
  input  logic [CW-1:0] fast_len,
  output logic          src_a,
  output logic          snk_a,
  output logic          src_b,
  output logic          snk_b,
  output logic          step_ready
);

  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] WAKE_V = WW'(WAKE_CYC);
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [1:0] {S_DIS, S_ON, S_OFF} st_t;

  st_t st;
  logic [3:0]    gate_q, tgt, gate_d;
  logic [3:0]    m_src, m_snk, m_cs, m_ck, on_pat;
  logic [CW-1:0] ocnt, fcnt, bcnt;
  logic [CW-1:0] t_eff, b_eff, f_eff;
  logic [WW-1:0] wcnt;
  logic          zero_hit, sr_ok, fast_now, kill;

  assign kill  = out_dis | fault | ~sleep_n;
  assign t_eff = (off_len == '0) ? ONE : off_len;
  assign b_eff = (blank_len == '0) ? ONE : blank_len;
  assign f_eff = (fast_len == '0) ? ONE : fast_len;

  // bit order {src_a, snk_a, src_b, snk_b}
  assign m_src  = pol ? 4'b0010 : 4'b1000;
  assign m_snk  = pol ? 4'b0100 : 4'b0001;
  assign m_cs   = pol ? 4'b0001 : 4'b0100;
  assign m_ck   = pol ? 4'b1000 : 4'b0010;
  assign on_pat = m_src | m_snk;

  assign sr_ok    = ~sr_dis & ~zero_hit & ~zero_det;
  assign fast_now = (decay_sel == 2'b01) || (decay_sel[1] && fcnt != '0);

  always_comb begin
    case (st)
      S_ON:    tgt = on_pat;
      S_OFF:   tgt = fast_now ? (sr_ok ? (m_cs | m_ck) : 4'b0000)
                              : (m_snk | (sr_ok ? m_cs : 4'b0000));
      default: tgt = 4'b0000;
    endcase
  end

  always_comb begin
    gate_d[3:2] = ((gate_q[3] & tgt[2]) | (gate_q[2] & tgt[3])) ? 2'b00 : tgt[3:2];
    gate_d[1:0] = ((gate_q[1] & tgt[0]) | (gate_q[0] & tgt[1])) ? 2'b00 : tgt[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_DIS;
      gate_q   <= '0;
      ocnt     <= '0;
      fcnt     <= '0;
      bcnt     <= '0;
      zero_hit <= 1'b0;
    end else begin
      gate_q <= kill ? 4'b0000 : gate_d;
      if ((kill ? 4'b0000 : gate_d) != gate_q) bcnt <= b_eff;
      else if (bcnt != '0)                      bcnt <= bcnt - ONE;
      if (kill) begin
        st       <= S_DIS;
        zero_hit <= 1'b0;
      end else begin
        case (st)
          S_DIS: st <= S_ON;
          S_ON: if (trip && bcnt == '0 && gate_q == on_pat) begin
            st       <= S_OFF;
            ocnt     <= t_eff - ONE;
            fcnt     <= f_eff;
            zero_hit <= 1'b0;
          end
          S_OFF: begin
            if (fcnt != '0) fcnt <= fcnt - ONE;
            if (zero_det)   zero_hit <= 1'b1;
            if (ocnt == '0) st <= S_ON;
            else            ocnt <= ocnt - ONE;
          end
          default: st <= S_DIS;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sleep_n) wcnt <= WAKE_V;
    else if (wcnt != '0)    wcnt <= wcnt - WW'(1);
  end

  assign step_ready = sleep_n && (wcnt == '0);
  assign {src_a, snk_a, src_b, snk_b} = gate_q;

  p_leg_a_r10: assert property (@(posedge clk) disable iff (!rst_n) !(src_a && snk_a));
  p_leg_b_r10: assert property (@(posedge clk) disable iff (!rst_n) !(src_b && snk_b));
  p_dead_a_r10: assert property (@(posedge clk) disable iff (!rst_n) src_a |=> !snk_a);
  p_dead_a2_r10: assert property (@(posedge clk) disable iff (!rst_n) snk_a |=> !src_a);
  p_dead_b_r10: assert property (@(posedge clk) disable iff (!rst_n) src_b |=> !snk_b);
  p_dead_b2_r10: assert property (@(posedge clk) disable iff (!rst_n) snk_b |=> !src_b);
  p_kill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (gate_q == 4'b0000));
  p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF && $past(st) == S_ON) |-> ($past(bcnt) == '0 && $past(trip)));
  p_sleep_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !step_ready);

endmodule

// File: tb/chop_phase_ctrl_test.sv
`timescale 1ns/1ps
module chop_phase_ctrl_test;
  localparam int WAKE = 20;

  logic clk = 1'b0, rst_n = 1'b0, sleep_n = 1'b1, out_dis = 1'b1, fault = 1'b0;
  logic trip = 1'b0, pol = 1'b0, sr_dis = 1'b1, zero_det = 1'b0;
  logic [1:0] decay_sel = 2'b00;
  logic [7:0] off_len = 8'd1, blank_len = 8'd1, fast_len = 8'd1;
  logic src_a, snk_a, src_b, snk_b, step_ready;
  logic [3:0] gv;
  int total = 0, bad = 0;

  always #4 clk = ~clk;
  assign gv = {src_a, snk_a, src_b, snk_b};

  chop_phase_ctrl #(.CW(8), .WAKE_CYC(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .out_dis(out_dis), .fault(fault),
    .trip(trip), .pol(pol), .decay_sel(decay_sel), .sr_dis(sr_dis), .zero_det(zero_det),
    .off_len(off_len), .blank_len(blank_len), .fast_len(fast_len),
    .src_a(src_a), .snk_a(snk_a), .src_b(src_b), .snk_b(snk_b), .step_ready(step_ready));

  task automatic chk(input logic ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] filt(input logic [3:0] cur, input logic [3:0] t);
    logic [3:0] r;
    r[3:2] = ((cur[3] & t[2]) | (cur[2] & t[3])) ? 2'b00 : t[3:2];
    r[1:0] = ((cur[1] & t[0]) | (cur[0] & t[1])) ? 2'b00 : t[1:0];
    return r;
  endfunction

  function automatic logic [3:0] offpat(input logic p, input int d, input logic s,
                                        input int i, input int fe);
    logic [3:0] src, snk, cs, ck;
    logic fast;
    src = p ? 4'b0010 : 4'b1000;
    snk = p ? 4'b0100 : 4'b0001;
    cs  = p ? 4'b0001 : 4'b0100;
    ck  = p ? 4'b1000 : 4'b0010;
    fast = (d == 1) || (d >= 2 && i < fe);
    if (fast) return s ? 4'b0000 : (cs | ck);
    return snk | (s ? 4'b0000 : cs);
  endfunction

  // R2 R3 R4 R5 R6 R7 R8 R10 R12 checked cycle by cycle
  task automatic run_case(input logic p, input int d, input logic s, input int t, input int b, input int f);
    logic [3:0] on, e, prev, fa, fe_v;
    logic ok;
    int te, be, fe;
    te = (t == 0) ? 1 : t;
    be = (b == 0) ? 1 : b;
    fe = (f == 0) ? 1 : f;
    on = p ? 4'b0110 : 4'b1001;
    ok = 1'b1; fa = 4'b0; fe_v = 4'b0;
    @(negedge clk);
    out_dis = 1'b1; trip = 1'b1; zero_det = 1'b0;
    pol = p; decay_sel = 2'(d); sr_dis = s;
    off_len = 8'(t); blank_len = 8'(b); fast_len = 8'(f);
    repeat (2) @(negedge clk);
    out_dis = 1'b0;
    repeat (2) @(negedge clk);
    for (int j = 0; j < be + 2; j++) begin
      if (ok && gv !== on) begin ok = 1'b0; fa = gv; fe_v = on; end
      @(negedge clk);
    end
    prev = on;
    for (int i = 0; i < te; i++) begin
      e = filt(prev, offpat(p, d, s, i, fe));
      if (ok && gv !== e) begin ok = 1'b0; fa = gv; fe_v = e; end
      prev = e;
      @(negedge clk);
    end
    e = filt(prev, on);
    if (ok && gv !== e) begin ok = 1'b0; fa = gv; fe_v = e; end
    if (e != on) begin
      @(negedge clk);
      if (ok && gv !== on) begin ok = 1'b0; fa = gv; fe_v = on; end
    end
    chk(ok, $sformatf("R2 R3 R4 R5 R6 R7 R8 R10 R12 pol=%0d dec=%0d srdis=%0d off=%0d blank=%0d fast=%0d",
                      p, d, s, t, b, f), fa, fe_v);
    out_dis = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gv == 4'b0000 && !step_ready, "R1 reset state", gv, 4'b0000);
    rst_n = 1'b1;
    for (int p = 0; p < 2; p++)
      for (int d = 0; d < 4; d++)
        for (int s = 0; s < 2; s++)
          for (int t = 0; t < 5; t++)
            for (int b = 0; b < 3; b++)
              for (int f = 0; f < 4; f++)
                run_case(p[0], d, s[0], t, b, f);

    // R9: zero detect in slow decay with rectification, pol=0
    @(negedge clk);
    out_dis = 1'b1; trip = 1'b1; pol = 1'b0; decay_sel = 2'b00; sr_dis = 1'b0;
    off_len = 8'd10; blank_len = 8'd1;
    repeat (2) @(negedge clk);
    out_dis = 1'b0;
    repeat (2) @(negedge clk);
    chk(gv == 4'b1001, "R2 on pattern pol0", gv, 4'b1001);
    repeat (4) @(negedge clk);
    chk(gv == 4'b0101, "R5 slow decay with rectification", gv, 4'b0101);
    zero_det = 1'b1;
    @(negedge clk);
    zero_det = 1'b0;
    chk(gv == 4'b0001, "R9 complement off after zero", gv, 4'b0001);
    @(negedge clk);
    chk(gv == 4'b0001, "R9 complement stays off", gv, 4'b0001);

    // R11: fault and disable during on phase
    @(negedge clk);
    out_dis = 1'b1; pol = 1'b1; trip = 1'b0; sr_dis = 1'b1;
    repeat (2) @(negedge clk);
    out_dis = 1'b0;
    repeat (2) @(negedge clk);
    chk(gv == 4'b0110, "R2 on pattern pol1", gv, 4'b0110);
    fault = 1'b1;
    @(negedge clk);
    chk(gv == 4'b0000, "R11 fault forces off", gv, 4'b0000);
    fault = 1'b0;
    @(negedge clk);
    chk(gv == 4'b0000, "R11 one cycle before resume", gv, 4'b0000);
    @(negedge clk);
    chk(gv == 4'b0110, "R11 resume after fault", gv, 4'b0110);

    // R13: sleep and wake delay
    sleep_n = 1'b0;
    @(negedge clk);
    chk(gv == 4'b0000, "R11 sleep forces off", gv, 4'b0000);
    chk(!step_ready, "R13 not ready in sleep", {3'b0, step_ready}, 4'b0000);
    @(negedge clk);
    sleep_n = 1'b1;
    repeat (WAKE - 1) @(negedge clk);
    chk(!step_ready, "R13 not ready before wake count", {3'b0, step_ready}, 4'b0000);
    @(negedge clk);
    chk(step_ready, "R13 ready after wake count", {3'b0, step_ready}, 4'b0001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule